// File: doc/BRIEF.md
# FMA Special-Operand Exception Detector

This block sits next to a single-precision fused multiply-add datapath and watches the three operands of each operation. It sorts each operand into zero, finite, infinite, quiet NaN or signalling NaN. It then applies the selected operation variant as sign flips on the product and on the addend. From this it decides whether the result is a special value that must replace the arithmetic result. When it is, the block raises `override_valid`, supplies the replacement word and supplies the five-bit exception flag vector. The datapath keeps its own result and flags for ordinary finite arithmetic.

The invalid-operation flag follows the fused-operation NaN rules exactly. Invalid is raised for a signalling NaN in any operand. It is also raised when one multiplicand is infinite and the other is zero, even if the addend is a quiet NaN. Finally, it is raised when an infinite product meets an infinite addend of the opposite effective sign. A quiet NaN addend on its own never raises invalid. For example, (+0 × +0) − 0x7FC00000 overrides with the canonical NaN and flags 0x00.

With `REG_OUT` set (the default), the outputs are registered and appear one clock after the inputs. With it clear, the block is purely combinational.

Top module: `fma_special_detect`

## Requirements
- R1: Operands are taken as raw single-precision bit patterns, with no NaN-boxing interpretation. An operand is zero when (x & 0x7FFFFFFF) == 0, so the sign is ignored. It is a NaN when the exponent field [30:23] is all ones and the mantissa [22:0] is non-zero. A NaN is quiet when bit 22 is set and signalling when bit 22 is clear. It is infinite when the exponent is all ones and the mantissa is zero.
- R2: `flags` is five bits wide. Invalid-operation is bit 4 (value 0x10), and this block drives the other four bits to 0 in every cycle.
- R3: A signalling NaN in a, b or c, under any op, gives override_valid=1, result 0x7FC00000 and flags 0x10.
- R4: When one multiplicand is infinite and the other is zero, the block gives override_valid=1, result 0x7FC00000 and flags 0x10. This holds even when c is a quiet NaN.
- R5: When any operand is a quiet NaN, no operand is a signalling NaN, and the product is not infinity × zero, the block gives override_valid=1, result 0x7FC00000 and flags 0x00.
- R6: The op select is op[0] = negate the addend and op[1] = negate the product. So 00 is a·b+c, 01 is a·b−c, 10 is −(a·b)+c and 11 is −(a·b)−c.
- R7: When the product is infinite and not invalid, and there are no NaNs, the block outputs an infinity with the product's effective sign (sign a ^ sign b ^ op[1]) and flags 0x00. This applies when the addend is finite or is an infinity of the same effective sign.
- R8: When the product is finite (no NaNs) and c is infinite, the block outputs an infinity with the addend's effective sign (sign c ^ op[0]) and flags 0x00.
- R9: An infinite product plus an infinite addend of the opposite effective sign gives override_valid=1, result 0x7FC00000 and flags 0x10.
- R10: When all three operands are non-NaN and non-infinite, override_valid, override_result and flags are all 0.
- R11: When in_valid is 0, all outputs are 0. With REG_OUT=1, outputs follow their inputs by exactly one clock, and an active-low reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when REG_OUT=1) |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 2 | Variant: bit 0 negates addend, bit 1 negates product |
| a | input | 32 | First multiplicand, raw single-precision bits |
| b | input | 32 | Second multiplicand, raw single-precision bits |
| c | input | 32 | Addend, raw single-precision bits |
| override_valid | output | 1 | Result is special and replaces the datapath result |
| override_result | output | 32 | Replacement result word (0 when not overriding) |
| flags | output | 5 | Exception flags, bit 4 = invalid operation |

## Verification
The main target is (+0 × +0) with a quiet NaN addend. A detector that raises invalid whenever a quiet NaN addend is present reports 0x10 there instead of 0x00. The bench also drives the opposite case, infinity × zero with a quiet NaN addend. A detector that lets the quiet NaN win would miss the flag. Sweeps over all four op values with signed infinities catch a swapped negation bit, because the sign of the result infinity flips and the opposite-sign infinity cancellation lands on the wrong cases. Signalling and quiet NaNs that differ only in bit 22, negative zeros and maximum-exponent finite values probe the classifier boundaries. A randomised mix of special operands with toggled valid strobes covers the remaining combinations and the one-cycle latency.

// File: rtl/fma_special_detect.sv
module fma_special_detect #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [31:0] c,
  output logic        override_valid,
  output logic [31:0] override_result,
  output logic [4:0]  flags
);
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;
  localparam int          NV_POS    = 4;

  // {is_zero, is_inf, is_nan, is_snan}
  function automatic logic [3:0] sort_op(input logic [31:0] x);
    logic exp_max, man_nz;
    exp_max = &x[30:23];
    man_nz  = |x[22:0];
    return {~|x[30:0], exp_max & ~man_nz, exp_max & man_nz, exp_max & man_nz & ~x[22]};
  endfunction

  logic [3:0] ka, kb, kc;
  assign ka = sort_op(a);
  assign kb = sort_op(b);
  assign kc = sort_op(c);

  logic any_nan, any_snan, inf_x_zero, prod_inf, add_inf;
  logic prod_sign, add_sign, inf_clash, invalid, special;
  logic [31:0] res_c;

  assign any_nan    = ka[1] | kb[1] | kc[1];
  assign any_snan   = ka[0] | kb[0] | kc[0];
  assign inf_x_zero = (ka[2] & kb[3]) | (kb[2] & ka[3]);
  assign prod_inf   = (ka[2] | kb[2]) & ~inf_x_zero & ~ka[1] & ~kb[1];
  assign add_inf    = kc[2];
  assign prod_sign  = a[31] ^ b[31] ^ op[1];
  assign add_sign   = c[31] ^ op[0];
  assign inf_clash  = prod_inf & add_inf & (prod_sign != add_sign);
  assign invalid    = any_snan | inf_x_zero | inf_clash;
  assign special    = any_nan | invalid | prod_inf | add_inf;

  always_comb begin
    if (any_nan || invalid) res_c = CANON_NAN;
    else if (prod_inf)      res_c = {prod_sign, 8'hFF, 23'd0};
    else if (add_inf)       res_c = {add_sign, 8'hFF, 23'd0};
    else                    res_c = 32'd0;
  end

  logic        ov_c;
  logic [31:0] rs_c;
  logic [4:0]  fl_c;
  assign ov_c = in_valid & special;
  assign rs_c = ov_c ? res_c : 32'd0;
  assign fl_c = (in_valid & invalid) ? 5'(1 << NV_POS) : 5'd0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          override_valid  <= 1'b0;
          override_result <= 32'd0;
          flags           <= 5'd0;
        end else begin
          override_valid  <= ov_c;
          override_result <= rs_c;
          flags           <= fl_c;
        end
      end
    end else begin : g_comb
      assign override_valid  = ov_c;
      assign override_result = rs_c;
      assign flags           = fl_c;
    end
  endgenerate
endmodule

// File: rtl/fma_special_detect_chk.sv
module fma_special_detect_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [31:0] c,
  input logic        override_valid,
  input logic [31:0] override_result,
  input logic [4:0]  flags
);
  function automatic logic f_inf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 23'd0);
  endfunction
  function automatic logic f_zero(input logic [31:0] x);
    return (x & 32'h7FFF_FFFF) == 32'd0;
  endfunction
  function automatic logic f_snan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0) && !x[22];
  endfunction
  function automatic logic f_qnan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && x[22];
  endfunction

  logic inf0_now, snan_now, qnan_c_only;
  assign inf0_now    = (f_inf(a) && f_zero(b)) || (f_inf(b) && f_zero(a));
  assign snan_now    = f_snan(a) || f_snan(b) || f_snan(c);
  assign qnan_c_only = f_qnan(c) && !snan_now && !inf0_now;

  generate
    if (REG_OUT) begin : g_chk
      a_r2_only_nv_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3:0] == 4'd0);

      a_r4_inf_times_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inf0_now) |=> (override_valid && flags == 5'h10 && override_result == 32'h7FC0_0000));

      a_r5_qnan_addend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && qnan_c_only) |=> (override_valid && flags == 5'h00 && override_result == 32'h7FC0_0000));

      a_r3_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan_now) |=> (flags == 5'h10 && override_result == 32'h7FC0_0000));

      a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!override_valid && flags == 5'd0 && override_result == 32'd0));

      a_r10_no_flag_without_override: assert property (@(posedge clk) disable iff (!rst_n)
        !override_valid |-> (flags == 5'd0 && override_result == 32'd0));
    end
  endgenerate
endmodule

bind fma_special_detect fma_special_detect_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b), .c(c),
  .override_valid(override_valid), .override_result(override_result), .flags(flags)
);

// File: tb/fma_special_detect_test.sv
module fma_special_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = 32'd0, b = 32'd0, c = 32'd0;
  logic        override_valid;
  logic [31:0] override_result;
  logic [4:0]  flags;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fma_special_detect uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b), .c(c),
    .override_valid(override_valid), .override_result(override_result), .flags(flags)
  );

  localparam logic [31:0] QN  = 32'h7FC0_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ  = 32'h0000_0000;
  localparam logic [31:0] NZ  = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000;
  localparam logic [31:0] SN  = 32'h7F80_0001;

  // kind: 0 zero, 1 finite, 2 inf, 3 qnan, 4 snan
  function automatic int kind(input logic [31:0] x);
    int e = int'(x[30:23]);
    int m = int'(x[22:0]);
    if (e == 255 && m == 0) return 2;
    if (e == 255) return (m >= 32'h40_0000) ? 3 : 4;
    if (e == 0 && m == 0) return 0;
    return 1;
  endfunction

  task automatic model(input logic [31:0] xa, xb, xc, input logic [1:0] xo, input logic v,
                       output logic eov, output logic [31:0] eres, output logic [4:0] efl,
                       output string tag);
    int ka = kind(xa), kb = kind(xb), kc = kind(xc);
    int ps, cs;
    eov = 0; eres = 0; efl = 0; tag = "R10";
    ps = (xa[31] ^ xb[31] ^ xo[1]) ? 1 : 0;
    cs = (xc[31] ^ xo[0]) ? 1 : 0;
    if (ka == 4 || kb == 4 || kc == 4) begin eov = 1; eres = QN; efl = 5'h10; tag = "R3"; end
    else if ((ka == 2 && kb == 0) || (ka == 0 && kb == 2)) begin eov = 1; eres = QN; efl = 5'h10; tag = "R4"; end
    else if (ka == 3 || kb == 3 || kc == 3) begin eov = 1; eres = QN; tag = "R5"; end
    else if ((ka == 2 || kb == 2) && kc == 2 && ps != cs) begin eov = 1; eres = QN; efl = 5'h10; tag = "R9"; end
    else if (ka == 2 || kb == 2) begin eov = 1; eres = {ps[0], 31'h7F80_0000}; tag = "R7"; end
    else if (kc == 2) begin eov = 1; eres = {cs[0], 31'h7F80_0000}; tag = "R8"; end
    if (!v) begin eov = 0; eres = 0; efl = 0; tag = "R11"; end
  endtask

  task automatic apply(input logic [31:0] xa, xb, xc, input logic [1:0] xo, input logic v);
    logic eov; logic [31:0] eres; logic [4:0] efl; string tag;
    model(xa, xb, xc, xo, v, eov, eres, efl, tag);
    a = xa; b = xb; c = xc; op = xo; in_valid = v;
    @(negedge clk);
    n_vec++;
    if (override_valid !== eov || override_result !== eres || flags !== efl) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h c=%h op=%0d: got ov=%0b res=%h fl=%h exp ov=%0b res=%h fl=%h",
               tag, xa, xb, xc, xo, override_valid, override_result, flags, eov, eres, efl);
    end
  endtask

  initial begin
    logic [31:0] pool [16];
    pool = '{PZ, NZ, ONE, 32'hC020_0000, 32'h0000_0001, PINF, NINF, QN,
             32'h7FC0_0001, 32'hFFC0_0000, SN, 32'hFFA0_0000, 32'h7F7F_FFFF,
             32'h0080_0000, 32'h7FBF_FFFF, 32'hFF80_0000};
    repeat (3) @(negedge clk);
    n_vec++;
    if (override_valid !== 1'b0 || override_result !== 32'd0 || flags !== 5'd0) begin
      n_bad++;
      $display("FAIL R11 reset: got ov=%0b res=%h fl=%h exp 0 0 0", override_valid, override_result, flags);
    end
    rst_n = 1'b1;
    apply(PZ, PZ, QN, 2'b01, 1);            // R5 headline case: flags 0x00
    apply(PZ, PZ, QN, 2'b00, 1);            // R5
    apply(NZ, ONE, 32'hFFC0_0000, 2'b11, 1);// R5
    apply(PINF, PZ, QN, 2'b01, 1);          // R4 with qNaN addend
    apply(NZ, NINF, ONE, 2'b00, 1);         // R4
    apply(ONE, ONE, SN, 2'b00, 1);          // R3
    apply(32'hFFA0_0000, ONE, ONE, 2'b10, 1); // R3
    apply(32'h7FBF_FFFF, PZ, QN, 2'b00, 1); // R1 sNaN with qNaN addend
    for (int o = 0; o < 4; o++) begin       // R6 R7 R8 R9 over all ops
      apply(PINF, ONE, ONE, 2'(o), 1);
      apply(NINF, ONE, PINF, 2'(o), 1);
      apply(ONE, ONE, NINF, 2'(o), 1);
      apply(PINF, 32'hC020_0000, PINF, 2'(o), 1);
    end
    apply(32'h7F7F_FFFF, 32'h7F7F_FFFF, ONE, 2'b00, 1); // R10 / R1 boundary
    apply(NZ, PZ, NZ, 2'b11, 1);                        // R10
    apply(PINF, PZ, SN, 2'b00, 0);                      // R11 idle
    for (int i = 0; i < 3000; i++) begin
      apply(pool[$urandom_range(15)], pool[$urandom_range(15)], pool[$urandom_range(15)],
            2'($urandom_range(3)), ($urandom_range(7) != 0));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule